// File: doc/BRIEF.md
# Dual-Select Serial Register and FIFO Port

This block is the serial slave port of a radio controller. A host reaches it through a serial clock, one data line that is shared by both directions, and two active-low selects. The data line is modelled as an input, an output and an output enable. The register select opens a two-byte cycle: a command byte, then a data byte. The command byte carries a read flag in its top bit and a 7-bit address in its lower bits. The FIFO select opens a stream with no header. Every eight clocks move one whole byte to or from the packet FIFO, and a FIFO direction bit held elsewhere in the register map picks the direction. All serial fields move most significant bit first. The host samples on the rising clock and the slave launches on the falling clock (clock idles low).

Inside, the inputs are synchronised into the system clock domain and the clock edges are detected there. One state machine then runs the protocol. Its states are IDLE, CMD (shifting in the command byte), RD_FETCH (one cycle to capture register read data), RD_DATA (driving the read byte), WR_DATA (shifting in the write byte), DONE (waiting for deselect), FIFO_WR, FIFO_RD and CONFLICT. The transitions are:
- IDLE to CMD when only the register select falls.
- IDLE to FIFO_RD or FIFO_WR when only the FIFO select falls, according to the direction bit.
- CMD to RD_FETCH or WR_DATA after the eighth rising edge, according to the read flag.
- RD_FETCH to RD_DATA after one cycle.
- WR_DATA to DONE after the eighth rising edge.
- Any state to CONFLICT when both selects are low.
- Any state other than IDLE back to IDLE when both selects are high.

The address is decoded into banks. A register access is refused when the address is past the map, or when it falls in the status bank while the radio is asleep. A refused access reads back as zero and drops writes.

Top module: `spi_dual_slave`

## Requirements
- R1: A register cycle whose command byte has bit 7 = 0 gives exactly one reg_wr_en pulse after the 16th rising clock, with reg_addr = command bits 6:0 and reg_wdata = the second byte, both assembled MSB first.
- R2: A command byte with bit 7 = 1 gives one reg_rd_en pulse after the 8th rising clock. The register value then appears on sdio_out MSB first, one bit launched per falling clock, so the host reads it on rising clocks 9 to 16.
- R3: sdio_oe stays low through the command byte and through every write. It goes high at the first falling clock after the 8th rising clock of a register read. It falls only once the select has been deasserted.
- R4: reg_bank reports the bank of the accessed address. The codes are 0 for 0x00-0x0B, 1 for 0x0C-0x17, 2 for 0x18-0x1F, 3 for 0x20-0x37, 4 for 0x38-0x54, 5 for 0x55-0x5F, 6 for 0x60-0x6A, 7 for 0x6B-0x71 and 8 above 0x71.
- R5: An address above 0x71 gives no reg_rd_en or reg_wr_en pulse, and a read of it returns 0x00.
- R6: While asleep is high, addresses 0x6B-0x71 give no strobe and read as 0x00, and other banks are accessed normally.
- R7: With fifo_dir_rd = 0, each 8 rising clocks under the FIFO select give one fifo_push pulse, with the byte assembled MSB first.
- R8: With fifo_dir_rd = 1, the head byte fifo_rdata is driven MSB first from the moment the select asserts. One fifo_pop pulse follows each completed byte, and the next head byte is driven from the following falling clock.
- R9: While both selects are low, no strobe is issued and the line is not driven. cs_conflict rises and stays set until reset, and later cycles work normally.
- R10: After reset, sdio_oe, every strobe and cs_conflict are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idles low |
| reg_cs_n | input | 1 | Register select, active low |
| fifo_cs_n | input | 1 | FIFO select, active low |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Data driven onto the line |
| sdio_oe | output | 1 | Output enable of the data line |
| asleep | input | 1 | Radio is in its sleep state |
| fifo_dir_rd | input | 1 | FIFO stream direction, 1 = host reads |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid the cycle after reg_rd_en |
| reg_bank | output | 4 | Bank code of reg_addr |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write byte |
| fifo_pop | output | 1 | FIFO read strobe |
| fifo_rdata | input | 8 | FIFO head byte, show-ahead |
| cs_conflict | output | 1 | Sticky flag: both selects were seen low |

## Verification
The assertions assume several things about the inputs:
- asleep holds steady from the command byte to the end of its cycle.
- The serial clock idles low whenever a select changes.
- Each clock phase lasts several system clocks, so synchronised edges never merge.

The bench keeps asleep fixed inside every cycle. It runs each serial half period for eight system clocks, and it changes a select only with the serial clock low and after a settling gap. The conflict case lowers both selects together before any clock edge.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t SYS_BASE  = 7'h0C;
    localparam addr_t FREQ_BASE = 7'h18;
    localparam addr_t RATE_BASE = 7'h20;
    localparam addr_t BASE_BASE = 7'h38;
    localparam addr_t TX_BASE   = 7'h55;
    localparam addr_t CTL1_BASE = 7'h60;
    localparam addr_t CTL2_BASE = 7'h6B;
    localparam addr_t MAP_LAST  = 7'h71;

    typedef enum logic [3:0] {
        BK_CORE = 4'd0,
        BK_SYS  = 4'd1,
        BK_FREQ = 4'd2,
        BK_RATE = 4'd3,
        BK_BASE = 4'd4,
        BK_TX   = 4'd5,
        BK_CTL1 = 4'd6,
        BK_CTL2 = 4'd7,
        BK_NONE = 4'd8
    } bank_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_RD_FETCH,
        S_RD_DATA,
        S_WR_DATA,
        S_DONE,
        S_FIFO_WR,
        S_FIFO_RD,
        S_CONFLICT
    } state_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int WIDTH = 5,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < STAGES; g++) begin : stg
        logic [WIDTH-1:0] q;
        if (g == 0) begin : first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= din;
            end
        end else begin : later
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= stg[g-1].q;
            end
        end
    end
    assign dout = stg[STAGES-1].q;
endmodule

// File: rtl/spi_bank_decode.sv
module spi_bank_decode
    import spi_dual_pkg::*;
(
    input  addr_t addr,
    output bank_e bank
);
    always_comb begin
        if (addr > MAP_LAST)        bank = BK_NONE;
        else if (addr >= CTL2_BASE) bank = BK_CTL2;
        else if (addr >= CTL1_BASE) bank = BK_CTL1;
        else if (addr >= TX_BASE)   bank = BK_TX;
        else if (addr >= BASE_BASE) bank = BK_BASE;
        else if (addr >= RATE_BASE) bank = BK_RATE;
        else if (addr >= FREQ_BASE) bank = BK_FREQ;
        else if (addr >= SYS_BASE)  bank = BK_SYS;
        else                        bank = BK_CORE;
    end
endmodule

// File: rtl/spi_dual_slave.sv
module spi_dual_slave
    import spi_dual_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              reg_cs_n,
    input  logic              fifo_cs_n,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    input  logic              asleep,
    input  logic              fifo_dir_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [3:0]        reg_bank,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_pop,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              cs_conflict
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam int NSYNC = 5;

    // synchronised pins: {asleep, data, fifo select, register select, clock}
    logic [NSYNC-1:0] raw_in, syn_in;
    assign raw_in = {asleep, sdio_in, fifo_cs_n, reg_cs_n, sclk};

    spi_in_sync #(
        .WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(5'b00110)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(syn_in)
    );

    logic sclk_s, rcs_s, fcs_s, sdi_s, sleep_s, sclk_q;
    assign sclk_s  = syn_in[0];
    assign rcs_s   = syn_in[1];
    assign fcs_s   = syn_in[2];
    assign sdi_s   = syn_in[3];
    assign sleep_s = syn_in[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    logic rise, fall, both_low, both_high;
    assign rise      = sclk_s & ~sclk_q;
    assign fall      = ~sclk_s & sclk_q;
    assign both_low  = ~rcs_s & ~fcs_s;
    assign both_high = rcs_s & fcs_s;

    state_e                state, state_nx;
    logic [CNT_W-1:0]      cnt;
    logic [DATA_W-1:0]     in_sh, out_sh, byte_w;
    logic                  launched, allow_q;
    bank_e                 bank_w, bank_q;
    logic                  allow_w;

    assign byte_w  = {in_sh[DATA_W-2:0], sdi_s};

    spi_bank_decode u_dec (
        .addr(byte_w[ADDR_W-1:0]),
        .bank(bank_w)
    );

    assign allow_w  = (bank_w != BK_NONE) && !((bank_w == BK_CTL2) && sleep_s);
    assign reg_bank = bank_q;
    assign sdio_oe  = ((state == S_RD_DATA) && launched) || (state == S_FIFO_RD);
    assign sdio_out = sdio_oe & out_sh[DATA_W-1];

    // next-state logic
    always_comb begin
        state_nx = state;
        if (both_low) begin
            state_nx = S_CONFLICT;
        end else if (both_high && state != S_IDLE) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (!rcs_s)      state_nx = S_CMD;
                    else if (!fcs_s) state_nx = fifo_dir_rd ? S_FIFO_RD : S_FIFO_WR;
                end
                S_CMD: begin
                    if (rise && cnt == LAST_BIT)
                        state_nx = byte_w[DATA_W-1] ? S_RD_FETCH : S_WR_DATA;
                end
                S_RD_FETCH: state_nx = S_RD_DATA;
                S_WR_DATA: begin
                    if (rise && cnt == LAST_BIT) state_nx = S_DONE;
                end
                S_RD_DATA, S_DONE, S_FIFO_WR, S_FIFO_RD, S_CONFLICT: state_nx = state;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            in_sh       <= '0;
            out_sh      <= '0;
            launched    <= 1'b0;
            allow_q     <= 1'b0;
            bank_q      <= BK_CORE;
            reg_addr    <= '0;
            reg_wdata   <= '0;
            reg_wr_en   <= 1'b0;
            reg_rd_en   <= 1'b0;
            fifo_push   <= 1'b0;
            fifo_wdata  <= '0;
            fifo_pop    <= 1'b0;
            cs_conflict <= 1'b0;
        end else begin
            reg_wr_en <= 1'b0;
            reg_rd_en <= 1'b0;
            fifo_push <= 1'b0;
            fifo_pop  <= 1'b0;
            if (both_low) cs_conflict <= 1'b1;
            if (!both_low) begin
                case (state)
                    S_IDLE: begin
                        cnt      <= '0;
                        in_sh    <= '0;
                        launched <= 1'b0;
                        if (rcs_s && !fcs_s && fifo_dir_rd) out_sh <= fifo_rdata;
                    end
                    S_CMD: begin
                        if (rise) begin
                            in_sh <= byte_w;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                reg_addr  <= byte_w[ADDR_W-1:0];
                                bank_q    <= bank_w;
                                allow_q   <= allow_w;
                                reg_rd_en <= byte_w[DATA_W-1] & allow_w;
                                cnt       <= '0;
                            end
                        end
                    end
                    S_RD_FETCH: begin
                        out_sh   <= allow_q ? reg_rdata : '0;
                        launched <= 1'b0;
                    end
                    S_RD_DATA: begin
                        if (fall) begin
                            if (!launched) launched <= 1'b1;
                            else           out_sh   <= {out_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                    S_WR_DATA: begin
                        if (rise) begin
                            in_sh <= byte_w;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                reg_wdata <= byte_w;
                                reg_wr_en <= allow_q;
                            end
                        end
                    end
                    S_FIFO_WR: begin
                        if (rise) begin
                            in_sh <= byte_w;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                fifo_wdata <= byte_w;
                                fifo_push  <= 1'b1;
                            end
                        end
                    end
                    S_FIFO_RD: begin
                        if (rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) fifo_pop <= 1'b1;
                        end else if (fall) begin
                            if (cnt == '0) out_sh <= fifo_rdata;
                            else           out_sh <= {out_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_en, reg_rd_en, fifo_push, fifo_pop}));

    assert_read_before_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !sdio_oe);

    assert_drive_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> (!$past(both_high) && !reg_wr_en && !fifo_push));

    assert_range_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |-> (reg_bank != 4'(BK_NONE)));

    assert_sleep_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr_en || reg_rd_en) && reg_bank == 4'(BK_CTL2)) |-> !sleep_s);

    assert_push_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> $past(rise));

    assert_pop_while_driving_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> sdio_oe);

    assert_conflict_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        both_low |=> !(reg_wr_en || reg_rd_en || fifo_push || fifo_pop));

    assert_conflict_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        both_low |=> cs_conflict);
endmodule

// File: tb/spi_dual_slave_test.sv
module spi_dual_slave_test;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, reg_cs_n = 1'b1, fifo_cs_n = 1'b1, sdi_h = 1'b0;
    logic asleep = 1'b0, fifo_dir_rd = 1'b0;
    logic sdio_out, sdio_oe, reg_wr_en, reg_rd_en, fifo_push, fifo_pop, cs_conflict;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, fifo_wdata, fifo_rdata;
    logic [3:0] reg_bank;

    always #4 clk = ~clk;   // 125 MHz

    spi_dual_slave uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .reg_cs_n(reg_cs_n), .fifo_cs_n(fifo_cs_n),
        .sdio_in(sdi_h), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .asleep(asleep),
        .fifo_dir_rd(fifo_dir_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
        .reg_bank(reg_bank), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .cs_conflict(cs_conflict)
    );

    // register file and FIFO models
    logic [7:0] mem [128];
    logic [7:0] src [8];
    logic [7:0] pushed [8];
    int wr_cnt = 0, rd_cnt = 0, push_cnt = 0, pop_cnt = 0;
    logic [6:0] last_wa;
    logic [7:0] last_wd;
    logic [3:0] last_bank;

    assign reg_rdata  = mem[reg_addr];
    assign fifo_rdata = src[pop_cnt[2:0]];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_addr] <= reg_wdata;
            last_wa   <= reg_addr;
            last_wd   <= reg_wdata;
            last_bank <= reg_bank;
            wr_cnt    <= wr_cnt + 1;
        end
        if (reg_rd_en) begin
            rd_cnt    <= rd_cnt + 1;
            last_bank <= reg_bank;
        end
        if (fifo_push) begin
            pushed[push_cnt[2:0]] <= fifo_wdata;
            push_cnt <= push_cnt + 1;
        end
        if (fifo_pop) pop_cnt <= pop_cnt + 1;
    end

    int checks = 0, errors = 0;
    logic done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic b, output logic rb, output logic oe_s);
        sdi_h = b;
        repeat (HALF) @(negedge clk);
        rb = sdio_out;
        oe_s = sdio_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    // one register cycle; returns read byte and direction-control observations
    task automatic reg_cycle(input logic rd, input logic [6:0] a, input logic [7:0] wd,
                             output logic [7:0] rdat, output logic cmd_oe, output logic data_oe_all,
                             output logic data_oe_any);
        logic rb, oe_s;
        logic [7:0] cmd;
        cmd = {rd, a};
        cmd_oe = 1'b0; data_oe_all = 1'b1; data_oe_any = 1'b0; rdat = '0;
        @(negedge clk);
        reg_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(cmd[i], rb, oe_s);
            cmd_oe |= oe_s;
        end
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(wd[i], rb, oe_s);
            rdat[i] = rb;
            data_oe_all &= oe_s;
            data_oe_any |= oe_s;
        end
        repeat (HALF) @(negedge clk);
        reg_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r; logic c, all, any;
        reg_cycle(1'b0, a, d, r, c, all, any);
        check("R3 no drive during write", {31'd0, c | any}, 32'd0);
    endtask

    task automatic reg_read(input logic [6:0] a, output logic [7:0] d);
        logic c, all, any;
        reg_cycle(1'b1, a, 8'h00, d, c, all, any);
        check("R3 line released in command phase", {31'd0, c}, 32'd0);
        check("R3 line driven in read data phase", {31'd0, all}, 32'd1);
        check("R3 line released after deselect", {31'd0, sdio_oe}, 32'd0);
    endtask

    task automatic test_reset;
        check("R10 oe after reset", {31'd0, sdio_oe}, 32'd0);
        check("R10 strobes after reset", {28'd0, reg_wr_en, reg_rd_en, fifo_push, fifo_pop}, 32'd0);
        check("R10 conflict flag after reset", {31'd0, cs_conflict}, 32'd0);
    endtask

    task automatic test_write_read;
        logic [7:0] d;
        int w0, r0;
        w0 = wr_cnt;
        reg_write(7'h20, 8'hA5);
        check("R1 one write strobe", wr_cnt - w0, 1);
        check("R1 write address", {25'd0, last_wa}, 32'h20);
        check("R1 write data", {24'd0, last_wd}, 32'hA5);
        r0 = rd_cnt;
        reg_read(7'h20, d);
        check("R2 one read strobe", rd_cnt - r0, 1);
        check("R2 read data MSB first", {24'd0, d}, 32'hA5);
        reg_write(7'h21, 8'h3C);
        reg_read(7'h21, d);
        check("R2 second pattern", {24'd0, d}, 32'h3C);
    endtask

    task automatic test_banks;
        logic [6:0] addrs [9] = '{7'h0B, 7'h0C, 7'h1F, 7'h37, 7'h38, 7'h5F, 7'h60, 7'h6B, 7'h71};
        logic [3:0] codes [9] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd7};
        for (int i = 0; i < 9; i++) begin
            reg_write(addrs[i], 8'h40 + 8'(i));
            check("R4 bank code", {28'd0, last_bank}, {28'd0, codes[i]});
        end
    endtask

    task automatic test_range;
        logic [7:0] d;
        int w0, r0;
        mem[7'h72] = 8'h5A;
        r0 = rd_cnt;
        reg_read(7'h72, d);
        check("R5 out of map reads zero", {24'd0, d}, 32'h00);
        check("R5 no read strobe", rd_cnt - r0, 0);
        w0 = wr_cnt;
        reg_write(7'h7F, 8'hEE);
        check("R5 no write strobe", wr_cnt - w0, 0);
        check("R5 model untouched", {24'd0, mem[7'h7F]}, 32'h00);
    endtask

    task automatic test_sleep;
        logic [7:0] d;
        int w0;
        reg_write(7'h6C, 8'h77);
        asleep = 1'b1;
        repeat (4) @(negedge clk);
        w0 = wr_cnt;
        reg_write(7'h6C, 8'h11);
        check("R6 status write blocked asleep", wr_cnt - w0, 0);
        reg_read(7'h6C, d);
        check("R6 status reads zero asleep", {24'd0, d}, 32'h00);
        reg_read(7'h20, d);
        check("R6 other bank readable asleep", {24'd0, d}, 32'hA5);
        asleep = 1'b0;
        repeat (4) @(negedge clk);
        reg_read(7'h6C, d);
        check("R6 status kept its value", {24'd0, d}, 32'h77);
    endtask

    task automatic test_fifo_write;
        logic [7:0] bytes [3] = '{8'h81, 8'h7E, 8'hF0};
        logic rb, oe_s, any;
        int p0;
        p0 = push_cnt;
        any = 1'b0;
        fifo_dir_rd = 1'b0;
        @(negedge clk);
        fifo_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < 3; b++)
            for (int i = 7; i >= 0; i--) begin
                bit_xfer(bytes[b][i], rb, oe_s);
                any |= oe_s;
            end
        repeat (HALF) @(negedge clk);
        fifo_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        check("R7 push count", push_cnt - p0, 3);
        for (int b = 0; b < 3; b++)
            check("R7 pushed byte", {24'd0, pushed[(p0 + b) % 8]}, {24'd0, bytes[b]});
        check("R3 no drive in FIFO write", {31'd0, any}, 32'd0);
    endtask

    task automatic test_fifo_read;
        logic [7:0] got;
        logic rb, oe_s, all;
        int q0;
        q0 = pop_cnt;
        src[q0 % 8] = 8'hC3;
        src[(q0 + 1) % 8] = 8'h5A;
        fifo_dir_rd = 1'b1;
        all = 1'b1;
        @(negedge clk);
        fifo_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < 2; b++) begin
            for (int i = 7; i >= 0; i--) begin
                bit_xfer(1'b0, rb, oe_s);
                got[i] = rb;
                all &= oe_s;
            end
            check("R8 streamed byte", {24'd0, got}, (b == 0) ? 32'hC3 : 32'h5A);
        end
        repeat (HALF) @(negedge clk);
        fifo_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        fifo_dir_rd = 1'b0;
        check("R8 pop count", pop_cnt - q0, 2);
        check("R8 line driven throughout", {31'd0, all}, 32'd1);
        check("R8 released after deselect", {31'd0, sdio_oe}, 32'd0);
    endtask

    task automatic test_conflict;
        logic rb, oe_s, any;
        logic [7:0] d;
        logic [15:0] frame;
        int w0, p0;
        frame = {1'b0, 7'h20, 8'h11};
        w0 = wr_cnt; p0 = push_cnt; any = 1'b0;
        @(negedge clk);
        reg_cs_n = 1'b0;
        fifo_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 15; i >= 0; i--) begin
            bit_xfer(frame[i], rb, oe_s);
            any |= oe_s;
        end
        repeat (HALF) @(negedge clk);
        reg_cs_n = 1'b1;
        fifo_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        check("R9 no write under conflict", wr_cnt - w0, 0);
        check("R9 no push under conflict", push_cnt - p0, 0);
        check("R9 no drive under conflict", {31'd0, any}, 32'd0);
        check("R9 conflict flag set", {31'd0, cs_conflict}, 32'd1);
        reg_read(7'h20, d);
        check("R9 later cycle works", {24'd0, d}, 32'hA5);
        check("R9 conflict flag sticky", {31'd0, cs_conflict}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) begin src[i] = 8'h00; pushed[i] = 8'h00; end
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        test_reset();
        test_write_read();
        test_banks();
        test_range();
        test_sleep();
        test_fifo_write();
        test_fifo_read();
        test_conflict();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule